// File: doc/BRIEF.md
# Stereo Input Sample Buffer with Pointer-Collision Mute

This block sits between a writer that delivers stereo samples at one rate and a reader that takes them at a second, unrelated rate. It holds samples in a small circular store until the downstream filter stage asks for them. Both sides are single-cycle strobes in one core clock domain, so the block needs no clock-domain crossing for data. The only asynchronous input is the latency mode, which is resynchronised before use.

The read pointer normally trails the write pointer by a nominal gap. A mode input picks that gap. Short mode uses a quarter of the store and gives low delay. Long mode uses half of it, which gives more slack when the two rates drift apart. When the pointers meet, the block declares a collision. A meeting means either a read from an empty store or a write into a full one without a matching read. On a collision the block puts the read pointer back at the nominal gap. It also raises a mute flag, which stays high for a fixed number of output sample periods, counted as read strobes. A change of mode also recentres the read pointer, but it does not mute.

The mute flag comes from a two-state machine with states MUTE_CLEAR and MUTE_HELD. It has four transitions:
- ARM (MUTE_CLEAR to MUTE_HELD) on a collision.
- RESTART (MUTE_HELD to MUTE_HELD, count reloaded) on a collision while held.
- TICK (MUTE_HELD to MUTE_HELD, count minus one) on a read strobe.
- RELEASE (MUTE_HELD to MUTE_CLEAR) on the read strobe that uses up the count.

Top module: `sfifo_collision_mute`

## Requirements
- R1: Samples come out in the order they were written, with left and right kept paired. A read strobe on a non-empty store presents the oldest sample on `rd_left_o`/`rd_right_o` after the next clock edge, and the outputs hold between reads.
- R2: Reset clears the write pointer, the stored samples (all zero), both data outputs and the mute flag. It places the read pointer at the short-mode gap, so with defaults (32 entries) eight reads are served before the store is empty.
- R3: A read strobe while the store holds nothing is an underflow collision, and both data outputs become zero after that clock edge.
- R4: A write strobe without a read strobe while the store holds all DEPTH entries is an overflow collision. The sample is still stored.
- R5: After any collision the read pointer sits at the nominal gap behind the write pointer, where the write pointer already includes a write made in the same cycle. The occupancy then equals that gap: DEPTH/4 in short mode and DEPTH/2 in long mode.
- R6: `mute_o` rises after the clock edge of a collision and stays high through exactly MUTE_PERIODS (default 128) later read strobes. It falls after the edge of the last of them and does not change between reads.
- R7: A collision while `mute_o` is high reloads the full MUTE_PERIODS count.
- R8: `depth_long_i` (1 = long, 0 = short) passes through a two-flop synchroniser. One cycle after the synchronised value changes, the read pointer is recentred to the gap of the new mode.
- R9: A mode change on its own never raises `mute_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_long_i | input | 1 | Latency mode, asynchronous; 1 selects the long gap |
| wr_stb_i | input | 1 | Write strobe, one sample pair per strobe |
| wr_left_i | input | DATA_W | Left sample to store |
| wr_right_i | input | DATA_W | Right sample to store |
| rd_stb_i | input | 1 | Read strobe, one output sample period per strobe |
| rd_left_o | output | DATA_W | Left sample read out |
| rd_right_o | output | DATA_W | Right sample read out |
| mute_o | output | 1 | High while output data is invalid after a collision |

## Verification
The bench first uses paired write-and-read traffic, where occupancy never moves, to show ordering and channel pairing without any collision. It then uses read-only bursts from a known occupancy, which reach underflow on an exact strobe. That strobe tells the short gap from the long gap, and it also tells a correct recentre from an off-by-one. A write-only burst reaches overflow. Placing a second underflow partway through a mute window separates a reloaded count from a continuing one. Toggling the mode with no traffic shows that recentring happens without muting.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int CHANNELS = 2;

    typedef enum logic [0:0] {
        MUTE_CLEAR = 1'b0,
        MUTE_HELD  = 1'b1
    } mute_state_e;

endpackage

// File: rtl/sfifo_mode_sync.sv
module sfifo_mode_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic change_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= async_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign level_o  = chain_q[STAGES-1];
    assign change_o = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/sfifo_ptr_ctrl.sv
module sfifo_ptr_ctrl #(
    parameter int ADDR_W = 5,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int OCC_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              mode_chg,
    input  logic [OCC_W-1:0]  sep,
    output logic [ADDR_W-1:0] wr_ptr_o,
    output logic [ADDR_W-1:0] rd_ptr_o,
    output logic              rd_take_o,
    output logic              rd_zero_o,
    output logic              collision_o,
    output logic [OCC_W-1:0]  occ_o
);

    localparam logic [OCC_W-1:0]  OCC_FULL   = OCC_W'(DEPTH);
    localparam logic [OCC_W-1:0]  OCC_RESET  = OCC_W'(DEPTH / 4);
    localparam logic [ADDR_W-1:0] RD_RESET   = ADDR_W'(DEPTH - DEPTH / 4);

    logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [OCC_W-1:0]  occ_q;
    logic              underflow, overflow, recentre;
    logic [ADDR_W-1:0] wr_next;
    logic [OCC_W-1:0]  occ_step;

    always_comb begin
        underflow = rd_stb && (occ_q == '0);
        overflow  = wr_stb && !rd_stb && (occ_q == OCC_FULL);
        recentre  = underflow || overflow || mode_chg;
        wr_next   = wr_stb ? wr_ptr_q + 1'b1 : wr_ptr_q;
        occ_step  = occ_q;
        if (wr_stb) begin
            occ_step = occ_step + 1'b1;
        end
        if (rd_stb && (occ_q != '0)) begin
            occ_step = occ_step - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= RD_RESET;
            occ_q    <= OCC_RESET;
        end else begin
            wr_ptr_q <= wr_next;
            if (recentre) begin
                rd_ptr_q <= wr_next - sep[ADDR_W-1:0];
                occ_q    <= sep;
            end else begin
                if (rd_stb && (occ_q != '0)) begin
                    rd_ptr_q <= rd_ptr_q + 1'b1;
                end
                occ_q <= occ_step;
            end
        end
    end

    assign wr_ptr_o    = wr_ptr_q;
    assign rd_ptr_o    = rd_ptr_q;
    assign rd_take_o   = rd_stb && (occ_q != '0);
    assign rd_zero_o   = underflow;
    assign collision_o = underflow || overflow;
    assign occ_o       = occ_q;

endmodule

// File: rtl/sfifo_storage.sv
module sfifo_storage
    import sfifo_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 5,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CHANNELS-1:0][DATA_W-1:0] wr_data,
    input  logic                           rd_take,
    input  logic                           rd_zero,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [CHANNELS-1:0][DATA_W-1:0] rd_data
);

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        logic [DATA_W-1:0] cell_q [DEPTH];
        logic [DATA_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    cell_q[i] <= '0;
                end
            end else if (wr_en) begin
                cell_q[wr_addr] <= wr_data[ch];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q <= '0;
            end else if (rd_take) begin
                out_q <= cell_q[rd_addr];
            end else if (rd_zero) begin
                out_q <= '0;
            end
        end

        assign rd_data[ch] = out_q;
    end

endmodule

// File: rtl/sfifo_mute_fsm.sv
module sfifo_mute_fsm
    import sfifo_pkg::*;
#(
    parameter int MUTE_PERIODS = 128,
    localparam int CNT_W = $clog2(MUTE_PERIODS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic collision,
    input  logic rd_stb,
    output logic mute_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MUTE_PERIODS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    mute_state_e      state_q, state_n;
    logic [CNT_W-1:0] left_q, left_n;

    always_comb begin
        state_n = state_q;
        left_n  = left_q;
        unique case (state_q)
            MUTE_CLEAR: begin
                if (collision) begin
                    state_n = MUTE_HELD;
                    left_n  = CNT_LOAD;
                end
            end
            MUTE_HELD: begin
                if (collision) begin
                    left_n = CNT_LOAD;
                end else if (rd_stb) begin
                    if (left_q == CNT_LAST) begin
                        state_n = MUTE_CLEAR;
                        left_n  = '0;
                    end else begin
                        left_n = left_q - 1'b1;
                    end
                end
            end
            default: begin
                state_n = MUTE_CLEAR;
                left_n  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MUTE_CLEAR;
            left_q  <= '0;
        end else begin
            state_q <= state_n;
            left_q  <= left_n;
        end
    end

    always_comb begin
        unique case (state_q)
            MUTE_HELD:  mute_o = 1'b1;
            default:    mute_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sfifo_collision_mute.sv
module sfifo_collision_mute
    import sfifo_pkg::*;
#(
    parameter int DATA_W       = 24,
    parameter int ADDR_W       = 5,
    parameter int MUTE_PERIODS = 128,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              depth_long_i,
    input  logic              wr_stb_i,
    input  logic [DATA_W-1:0] wr_left_i,
    input  logic [DATA_W-1:0] wr_right_i,
    input  logic              rd_stb_i,
    output logic [DATA_W-1:0] rd_left_o,
    output logic [DATA_W-1:0] rd_right_o,
    output logic              mute_o
);

    localparam int DEPTH     = 1 << ADDR_W;
    localparam int OCC_W     = ADDR_W + 1;
    localparam int SEP_SHORT = DEPTH / 4;
    localparam int SEP_LONG  = DEPTH / 2;

    logic                            mode_long, mode_chg;
    logic [OCC_W-1:0]                sep;
    logic [ADDR_W-1:0]               wr_ptr, rd_ptr;
    logic                            rd_take, rd_zero, collision;
    logic [OCC_W-1:0]                occ;
    logic [CHANNELS-1:0][DATA_W-1:0] wr_pair, rd_pair;

    sfifo_mode_sync #(
        .STAGES   (SYNC_STAGES)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (depth_long_i),
        .level_o  (mode_long),
        .change_o (mode_chg)
    );

    assign sep = mode_long ? OCC_W'(SEP_LONG) : OCC_W'(SEP_SHORT);

    sfifo_ptr_ctrl #(
        .ADDR_W      (ADDR_W)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb_i),
        .rd_stb      (rd_stb_i),
        .mode_chg    (mode_chg),
        .sep         (sep),
        .wr_ptr_o    (wr_ptr),
        .rd_ptr_o    (rd_ptr),
        .rd_take_o   (rd_take),
        .rd_zero_o   (rd_zero),
        .collision_o (collision),
        .occ_o       (occ)
    );

    assign wr_pair[0] = wr_left_i;
    assign wr_pair[1] = wr_right_i;

    sfifo_storage #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb_i),
        .wr_addr (wr_ptr),
        .wr_data (wr_pair),
        .rd_take (rd_take),
        .rd_zero (rd_zero),
        .rd_addr (rd_ptr),
        .rd_data (rd_pair)
    );

    assign rd_left_o  = rd_pair[0];
    assign rd_right_o = rd_pair[1];

    sfifo_mute_fsm #(
        .MUTE_PERIODS (MUTE_PERIODS)
    ) u_mute (
        .clk          (clk),
        .rst_n        (rst_n),
        .collision    (collision),
        .rd_stb       (rd_stb_i),
        .mute_o       (mute_o)
    );

endmodule

// File: rtl/sfifo_collision_mute_chk.sv
module sfifo_collision_mute_chk #(
    parameter int DATA_W       = 24,
    parameter int DEPTH        = 32,
    parameter int OCC_W        = 6,
    parameter int MUTE_PERIODS = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic              collision,
    input logic              mode_chg,
    input logic [OCC_W-1:0]  occ,
    input logic [OCC_W-1:0]  sep,
    input logic              mute,
    input logic [DATA_W-1:0] rd_left,
    input logic [DATA_W-1:0] rd_right
);

    int unsigned reads_held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_held <= 0;
        end else if (collision) begin
            reads_held <= 0;
        end else if (mute && rd_stb) begin
            reads_held <= reads_held + 1;
        end
    end

    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && occ == '0) |=> (rd_left == '0 && rd_right == '0)); // R3

    AST_OVERFLOW_COLLIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rd_stb && occ == OCC_W'(DEPTH)) |-> collision); // R4

    AST_RECENTRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> (occ == $past(sep))); // R5

    AST_MUTE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> mute); // R6

    AST_MUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && !rd_stb) |=> mute); // R6

    AST_MUTE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute) |-> (reads_held == MUTE_PERIODS)); // R7

    AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute && mode_chg && !collision) |=> !mute); // R9

endmodule

bind sfifo_collision_mute sfifo_collision_mute_chk #(
    .DATA_W       (DATA_W),
    .DEPTH        (DEPTH),
    .OCC_W        (OCC_W),
    .MUTE_PERIODS (MUTE_PERIODS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb_i),
    .rd_stb    (rd_stb_i),
    .collision (collision),
    .mode_chg  (mode_chg),
    .occ       (occ),
    .sep       (sep),
    .mute      (mute_o),
    .rd_left   (rd_left_o),
    .rd_right  (rd_right_o)
);

// File: tb/sfifo_collision_mute_bench.sv
module sfifo_collision_mute_bench;

    localparam int DATA_W = 24;
    localparam int ADDR_W = 5;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MUTE_N = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              depth_long = 1'b0;
    logic              wr_stb = 1'b0;
    logic              rd_stb = 1'b0;
    logic [DATA_W-1:0] wr_left = '0;
    logic [DATA_W-1:0] wr_right = '0;
    logic [DATA_W-1:0] rd_left, rd_right;
    logic              mute;

    int checks = 0;
    int errors = 0;
    int sample_no = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sfifo_collision_mute #(
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .MUTE_PERIODS (MUTE_N),
        .SYNC_STAGES  (2)
    ) u_sfifo_collision_mute (
        .clk          (clk),
        .rst_n        (rst_n),
        .depth_long_i (depth_long),
        .wr_stb_i     (wr_stb),
        .wr_left_i    (wr_left),
        .wr_right_i   (wr_right),
        .rd_stb_i     (rd_stb),
        .rd_left_o    (rd_left),
        .rd_right_o   (rd_right),
        .mute_o       (mute)
    );

    // behavioural reference model
    logic [DATA_W-1:0] m_left [DEPTH];
    logic [DATA_W-1:0] m_right [DEPTH];
    logic [DATA_W-1:0] exp_left = '0, exp_right = '0;
    int  m_wp, m_rp, m_occ, m_left_cnt, gap, wnext;
    bit  ms1, ms2, mq, chg, under, over;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_left[i] = '0;
                m_right[i] = '0;
            end
            exp_left = '0; exp_right = '0;
            m_wp = 0; m_rp = DEPTH - DEPTH / 4; m_occ = DEPTH / 4;
            m_left_cnt = 0; ms1 = 0; ms2 = 0; mq = 0;
        end else begin
            chg   = (ms2 != mq);
            gap   = ms2 ? DEPTH / 2 : DEPTH / 4;
            under = rd_stb && (m_occ == 0);
            over  = wr_stb && !rd_stb && (m_occ == DEPTH);
            if (rd_stb && m_occ != 0) begin
                exp_left  = m_left[m_rp];
                exp_right = m_right[m_rp];
            end else if (under) begin
                exp_left = '0; exp_right = '0;
            end
            if (wr_stb) begin
                m_left[m_wp]  = wr_left;
                m_right[m_wp] = wr_right;
            end
            wnext = wr_stb ? (m_wp + 1) % DEPTH : m_wp;
            if (under || over || chg) begin
                m_rp  = (wnext - gap + DEPTH) % DEPTH;
                m_occ = gap;
            end else begin
                if (rd_stb && m_occ != 0) begin
                    m_rp  = (m_rp + 1) % DEPTH;
                    m_occ = m_occ - 1;
                end
                if (wr_stb) m_occ = m_occ + 1;
            end
            m_wp = wnext;
            if (under || over) m_left_cnt = MUTE_N;
            else if (rd_stb && m_left_cnt > 0) m_left_cnt = m_left_cnt - 1;
            mq = ms2; ms2 = ms1; ms1 = depth_long;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R1 left data", 32'(rd_left), 32'(exp_left));
            check("R1 right data", 32'(rd_right), 32'(exp_right));
            check("R6 mute vs model", 32'(mute), 32'(m_left_cnt > 0));
        end
    end

    task automatic step(bit w, bit r);
        wr_stb = w;
        rd_stb = r;
        if (w) begin
            sample_no++;
            wr_left  = DATA_W'(32'h00A0_0000 + sample_no);
            wr_right = ~wr_left;
        end
        @(negedge clk);
        wr_stb = 0;
        rd_stb = 0;
    endtask

    task automatic steps(int n, bit w, bit r);
        for (int i = 0; i < n; i++) step(w, r);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: reset state
        check("R2 mute after reset", 32'(mute), 32'd0);
        check("R2 left after reset", 32'(rd_left), 32'd0);
        // R2: eight reads served from the reset gap, the ninth underflows (R3)
        steps(8, 0, 1);
        check("R2 no collision within reset gap", 32'(mute), 32'd0);
        step(0, 1);
        check("R3 underflow raises mute", 32'(mute), 32'd1);
        check("R3 underflow zero data", 32'(rd_left), 32'd0);
        // R6: paired traffic releases after exactly 128 reads
        steps(MUTE_N - 1, 1, 1);
        check("R6 mute held through 127 reads", 32'(mute), 32'd1);
        step(1, 1);
        check("R6 mute released at read 128", 32'(mute), 32'd0);
        // R1: ordered paired traffic, checked per clock by the model
        steps(8, 1, 0);
        steps(40, 1, 1);
        steps(10, 1, 0);
        steps(10, 0, 1);
        // R5 and R7: underflow, then a second underflow inside the mute window
        steps(16, 0, 1);
        check("R5 no underflow yet", 32'(mute), 32'd0);
        step(0, 1);
        check("R5 underflow collision", 32'(mute), 32'd1);
        steps(60, 1, 1);
        steps(8, 0, 1);
        check("R5 recentred gap of eight", 32'(mute), 32'd1);
        step(0, 1);
        steps(MUTE_N - 1, 1, 1);
        check("R7 restart keeps mute high", 32'(mute), 32'd1);
        step(1, 1);
        check("R7 release after reloaded count", 32'(mute), 32'd0);
        // R4: overflow with writes only from a gap of eight
        steps(DEPTH - DEPTH / 4, 1, 0);
        check("R4 full store no collision", 32'(mute), 32'd0);
        step(1, 0);
        check("R4 overflow raises mute", 32'(mute), 32'd1);
        steps(MUTE_N, 1, 1);
        check("R4 recovered after overflow", 32'(mute), 32'd0);
        // R8 and R9: switch to long mode
        depth_long = 1;
        steps(5, 0, 0);
        check("R9 mode change without mute", 32'(mute), 32'd0);
        steps(16, 0, 1);
        check("R8 long gap serves sixteen", 32'(mute), 32'd0);
        step(0, 1);
        check("R8 long gap underflow", 32'(mute), 32'd1);
        steps(MUTE_N, 1, 1);
        depth_long = 0;
        steps(5, 0, 0);
        check("R9 return to short without mute", 32'(mute), 32'd0);
        steps(8, 0, 1);
        check("R8 short gap serves eight", 32'(mute), 32'd0);
        step(0, 1);
        check("R8 short gap underflow", 32'(mute), 32'd1);
        steps(MUTE_N, 1, 1);
        check("R6 final release", 32'(mute), 32'd0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule